// File: doc/BRIEF.md
# Delayed Configuration-Write to Special-Cycle Forwarder

This block sits inside a two-port bus bridge. It takes a configuration write from the initiator side that is meant to become a special cycle on the far bus. It handles the write as a delayed transaction. On the first attempt it stores the address and data, answers the initiator with a retry, and asks the far-side master to run the same address and data with the command rewritten to special cycle. Special cycles are claimed by no target, so the far-side attempt always ends in a master abort. The block treats that abort as a successful completion and never reports it as an error.

While the far-side attempt is outstanding, every configuration write from the initiator is retried. Once the abort has been seen, the next configuration write with the same address and data is finished with one data transfer. If that attempt asks for more than one data phase, the block disconnects in the first one. The stored entry is then released, and the block accepts a new request. Each initiator attempt is presented as a one-cycle strobe, and the block answers with a registered response one cycle later.

Top module: `cfg_spcyc_fwd`

## Requirements
- R1: After reset, `tgt_rsp_vld`, `tgt_trdy`, `tgt_stop`, `tgt_devsel` and `mst_req` are all low.
- R2: A configuration write (command 4'b1011) arriving while no entry is held is answered, one cycle after its strobe, with a retry: `tgt_rsp_vld`=1, `tgt_stop`=1, `tgt_devsel`=1, `tgt_trdy`=0. From that same edge, `mst_req` is high, with `mst_cmd`=4'b0001 and `mst_addr`/`mst_data` equal to the written address and data.
- R3: While the far-side attempt is outstanding, a repeat of the stored write is answered with a retry, and `mst_req` stays high.
- R4: A configuration write whose address or data differs from the stored entry is answered with a retry and leaves `mst_addr`/`mst_data` unchanged.
- R5: A pulse on `mst_mabort` while `mst_req` is high ends the far-side attempt: `mst_req` is low from the next edge, and the abort produces no response on the initiator side.
- R6: After the abort, a matching single-transfer attempt is answered with `tgt_trdy`=1, `tgt_devsel`=1, `tgt_stop`=0.
- R7: After the abort, a matching attempt that requests several transfers (`tgt_burst`=1) is answered with `tgt_trdy`=1, `tgt_stop`=1, `tgt_devsel`=1, which is a disconnect with data.
- R8: Once the completing response has been given, the entry is free. The next configuration write is captured as in R2.
- R9: An attempt with any command other than 4'b1011 gets no response (`tgt_rsp_vld`=0) and captures nothing.
- R10: A pulse on `mst_mabort` while no attempt is outstanding has no effect. A following configuration write is retried and captured, not completed.
- R11: An initiator attempt in the same cycle as the abort pulse is judged against the state before that edge, so it is retried. The following matching attempt completes.
- R12: After the abort but before completion, a non-matching configuration write is retried. The stored entry still completes on a later matching attempt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tgt_strobe | input | 1 | One-cycle strobe marking an initiator attempt |
| tgt_cmd | input | 4 | Bus command of the attempt |
| tgt_addr | input | AW | Address of the attempt |
| tgt_wdata | input | DW | Write data of the attempt |
| tgt_burst | input | 1 | Attempt requests more than one data transfer |
| tgt_rsp_vld | output | 1 | Registered response for the previous-cycle attempt |
| tgt_trdy | output | 1 | Data transfer accepted |
| tgt_stop | output | 1 | Stop requested (retry or disconnect) |
| tgt_devsel | output | 1 | Device claims the attempt |
| mst_req | output | 1 | Far-side special cycle requested |
| mst_cmd | output | 4 | Far-side command, special cycle code |
| mst_addr | output | AW | Far-side address, unchanged from the initiator |
| mst_data | output | DW | Far-side data, unchanged from the initiator |
| mst_mabort | input | 1 | Far-side attempt ended by master abort |

## Verification
An initiator attempt and the far-side abort can land in the same cycle. At that edge the attempt must still see the outstanding state, while the entry moves to completed. The bench drives the strobe and the abort pulse together on one edge. It expects a retry from that cycle with `mst_req` already low, and then expects the next matching attempt to finish with TRDY. A second overlap, a stray abort while the block is idle, is judged by showing that a fresh write is still retried and captured.

// File: rtl/cfgsc_pkg.sv
package cfgsc_pkg;

    localparam logic [3:0] CMD_CFG_WRITE = 4'b1011;
    localparam logic [3:0] CMD_SPECIAL   = 4'b0001;

    typedef enum logic [1:0] {
        ENT_EMPTY = 2'd0,
        ENT_WAIT  = 2'd1,
        ENT_DONE  = 2'd2
    } ent_state_e;

    typedef struct packed {
        logic trdy;
        logic stop;
        logic devsel;
    } tresp_t;

    function automatic tresp_t rsp_retry();
        tresp_t r;
        r.trdy   = 1'b0;
        r.stop   = 1'b1;
        r.devsel = 1'b1;
        return r;
    endfunction

    function automatic tresp_t rsp_transfer(input logic burst);
        tresp_t r;
        r.trdy   = 1'b1;
        r.stop   = burst;
        r.devsel = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/cfgsc_store.sv
module cfgsc_store #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cap_en,
    input  logic [AW-1:0] in_addr,
    input  logic [DW-1:0] in_data,
    output logic [AW-1:0] ent_addr,
    output logic [DW-1:0] ent_data,
    output logic          hit
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ent_addr <= '0;
            ent_data <= '0;
        end else if (cap_en) begin
            ent_addr <= in_addr;
            ent_data <= in_data;
        end
    end

    assign hit = (in_addr == ent_addr) && (in_data == ent_data);

    // Stored entry changes only on a capture (R4)
    assert_entry_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !cap_en |=> $stable(ent_addr) && $stable(ent_data));
endmodule

// File: rtl/cfgsc_track.sv
module cfgsc_track
    import cfgsc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       capture,
    input  logic       release_ent,
    input  logic       abort_seen,
    output ent_state_e state
);
    ent_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ENT_EMPTY: if (capture)     nxt = ENT_WAIT;
            ENT_WAIT:  if (abort_seen)  nxt = ENT_DONE;
            ENT_DONE:  if (release_ent) nxt = ENT_EMPTY;
            default:                    nxt = ENT_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ENT_EMPTY;
        else     state <= nxt;
    end

    // An abort outside the waiting state leaves the state alone (R10)
    assert_stray_abort_R10: assert property (@(posedge clk) disable iff (rst)
        (abort_seen && state == ENT_EMPTY && !capture) |=> state == ENT_EMPTY);
    // Completion is reached only through an abort (R5)
    assert_done_via_abort_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(state == ENT_DONE) |-> $past(abort_seen));
endmodule

// File: rtl/cfgsc_resp.sv
module cfgsc_resp
    import cfgsc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       strobe,
    input  logic [3:0] cmd,
    input  logic       burst,
    input  logic       hit,
    input  ent_state_e state,
    output logic       capture,
    output logic       release_ent,
    output logic       rsp_vld,
    output tresp_t     rsp
);
    logic   is_cfg;
    tresp_t rsp_nxt;

    assign is_cfg      = strobe && (cmd == CMD_CFG_WRITE);
    assign capture     = is_cfg && (state == ENT_EMPTY);
    assign release_ent = is_cfg && (state == ENT_DONE) && hit;

    always_comb begin
        if (release_ent) rsp_nxt = rsp_transfer(burst);
        else             rsp_nxt = rsp_retry();
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_vld <= 1'b0;
            rsp     <= '0;
        end else begin
            rsp_vld <= is_cfg;
            rsp     <= is_cfg ? rsp_nxt : '0;
        end
    end

    // A response only follows a configuration write attempt (R9)
    assert_rsp_cause_R9: assert property (@(posedge clk) disable iff (rst)
        rsp_vld |-> $past(strobe) && $past(cmd) == CMD_CFG_WRITE);
    // A retry always carries stop and devsel (R3)
    assert_retry_shape_R3: assert property (@(posedge clk) disable iff (rst)
        (rsp_vld && !rsp.trdy) |-> rsp.stop && rsp.devsel);
endmodule

// File: rtl/cfg_spcyc_fwd.sv
module cfg_spcyc_fwd
    import cfgsc_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tgt_strobe,
    input  logic [3:0]    tgt_cmd,
    input  logic [AW-1:0] tgt_addr,
    input  logic [DW-1:0] tgt_wdata,
    input  logic          tgt_burst,
    output logic          tgt_rsp_vld,
    output logic          tgt_trdy,
    output logic          tgt_stop,
    output logic          tgt_devsel,
    output logic          mst_req,
    output logic [3:0]    mst_cmd,
    output logic [AW-1:0] mst_addr,
    output logic [DW-1:0] mst_data,
    input  logic          mst_mabort
);
    ent_state_e state;
    logic       capture, release_ent, hit;
    tresp_t     rsp;

    cfgsc_store #(.AW(AW), .DW(DW)) u_store (
        .clk      (clk),
        .rst      (rst),
        .cap_en   (capture),
        .in_addr  (tgt_addr),
        .in_data  (tgt_wdata),
        .ent_addr (mst_addr),
        .ent_data (mst_data),
        .hit      (hit)
    );

    cfgsc_track u_track (
        .clk         (clk),
        .rst         (rst),
        .capture     (capture),
        .release_ent (release_ent),
        .abort_seen  (mst_mabort),
        .state       (state)
    );

    cfgsc_resp u_resp (
        .clk         (clk),
        .rst         (rst),
        .strobe      (tgt_strobe),
        .cmd         (tgt_cmd),
        .burst       (tgt_burst),
        .hit         (hit),
        .state       (state),
        .capture     (capture),
        .release_ent (release_ent),
        .rsp_vld     (tgt_rsp_vld),
        .rsp         (rsp)
    );

    assign tgt_trdy   = rsp.trdy;
    assign tgt_stop   = rsp.stop;
    assign tgt_devsel = rsp.devsel;
    assign mst_req    = (state == ENT_WAIT);
    assign mst_cmd    = CMD_SPECIAL;

    // Far-side request starts only from a captured initiator attempt (R2)
    assert_req_origin_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(mst_req) |-> $past(tgt_strobe) && $past(tgt_cmd) == CMD_CFG_WRITE);
    // Far-side address and data hold while the request is up (R4)
    assert_req_stable_R4: assert property (@(posedge clk) disable iff (rst)
        (mst_req && $past(mst_req)) |-> $stable(mst_addr) && $stable(mst_data));
    // A data transfer is never given while the far-side attempt runs (R6)
    assert_no_early_trdy_R6: assert property (@(posedge clk) disable iff (rst)
        tgt_trdy |-> !mst_req && !$past(mst_req));
    // Single transfer completes without stop (R6)
    assert_single_nostop_R6: assert property (@(posedge clk) disable iff (rst)
        (tgt_trdy && !$past(tgt_burst)) |-> !tgt_stop);
    // Abort drops the request on the next edge (R5)
    assert_abort_drop_R5: assert property (@(posedge clk) disable iff (rst)
        (mst_req && mst_mabort) |=> !mst_req);
endmodule

// File: tb/cfg_spcyc_fwd_bench.sv
module cfg_spcyc_fwd_bench;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam logic [3:0] CW = 4'b1011;
    localparam logic [3:0] SC = 4'b0001;

    logic          clk = 1'b0;
    logic          rst;
    logic          tgt_strobe, tgt_burst, mst_mabort;
    logic [3:0]    tgt_cmd;
    logic [AW-1:0] tgt_addr;
    logic [DW-1:0] tgt_wdata;
    logic          tgt_rsp_vld, tgt_trdy, tgt_stop, tgt_devsel, mst_req;
    logic [3:0]    mst_cmd;
    logic [AW-1:0] mst_addr;
    logic [DW-1:0] mst_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    cfg_spcyc_fwd #(.AW(AW), .DW(DW)) u_cfg_spcyc_fwd (
        .clk(clk), .rst(rst),
        .tgt_strobe(tgt_strobe), .tgt_cmd(tgt_cmd), .tgt_addr(tgt_addr),
        .tgt_wdata(tgt_wdata), .tgt_burst(tgt_burst),
        .tgt_rsp_vld(tgt_rsp_vld), .tgt_trdy(tgt_trdy), .tgt_stop(tgt_stop),
        .tgt_devsel(tgt_devsel), .mst_req(mst_req), .mst_cmd(mst_cmd),
        .mst_addr(mst_addr), .mst_data(mst_data), .mst_mabort(mst_mabort)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One attempt; returns sampled {vld,trdy,stop,devsel} one cycle later
    task automatic attempt(input logic [3:0] c, input logic [AW-1:0] a,
                           input logic [DW-1:0] d, input logic b, input logic ab,
                           output logic [3:0] r);
        @(negedge clk);
        tgt_strobe = 1'b1; tgt_cmd = c; tgt_addr = a; tgt_wdata = d;
        tgt_burst = b; mst_mabort = ab;
        @(negedge clk);
        tgt_strobe = 1'b0; mst_mabort = 1'b0; tgt_burst = 1'b0;
        r = {tgt_rsp_vld, tgt_trdy, tgt_stop, tgt_devsel};
    endtask

    task automatic abort_pulse();
        @(negedge clk);
        mst_mabort = 1'b1;
        @(negedge clk);
        mst_mabort = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 outputs after reset", {tgt_rsp_vld, tgt_trdy, tgt_stop, tgt_devsel, mst_req}, 5'b0);
    endtask

    task automatic t_first();
        logic [3:0] r;
        attempt(CW, 32'hA000_0010, 32'h0000_5A5A, 1'b0, 1'b0, r);
        check("R2 first write retried", r, 4'b1011);
        check("R2 far request", {mst_req, mst_cmd}, {1'b1, SC});
        check("R2 addr/data forwarded", {mst_addr, mst_data}, {32'hA000_0010, 32'h0000_5A5A});
    endtask

    task automatic t_pending();
        logic [3:0] r;
        attempt(CW, 32'hA000_0010, 32'h0000_5A5A, 1'b0, 1'b0, r);
        check("R3 repeat retried", r, 4'b1011);
        check("R3 request held", mst_req, 1'b1);
    endtask

    task automatic t_mismatch();
        logic [3:0] r;
        attempt(CW, 32'hB000_0020, 32'h0000_5A5A, 1'b0, 1'b0, r);
        check("R4 other addr retried", r, 4'b1011);
        attempt(CW, 32'hA000_0010, 32'h0000_1111, 1'b0, 1'b0, r);
        check("R4 other data retried", r, 4'b1011);
        check("R4 entry unchanged", {mst_addr, mst_data}, {32'hA000_0010, 32'h0000_5A5A});
    endtask

    task automatic t_nonconfig();
        logic [3:0] r;
        attempt(4'b0110, 32'hA000_0010, 32'h0000_5A5A, 1'b0, 1'b0, r);
        check("R9 other command ignored", r, 4'b0000);
        check("R9 entry unchanged", {mst_req, mst_addr}, {1'b1, 32'hA000_0010});
    endtask

    task automatic t_abort();
        abort_pulse();
        check("R5 request dropped", mst_req, 1'b0);
        check("R5 no initiator response", tgt_rsp_vld, 1'b0);
    endtask

    task automatic t_done_mismatch();
        logic [3:0] r;
        attempt(CW, 32'hC000_0000, 32'h0000_5A5A, 1'b0, 1'b0, r);
        check("R12 non-matching after abort retried", r, 4'b1011);
        check("R12 no new request", mst_req, 1'b0);
    endtask

    task automatic t_complete_single();
        logic [3:0] r;
        attempt(CW, 32'hA000_0010, 32'h0000_5A5A, 1'b0, 1'b0, r);
        check("R6 single transfer completes", r, 4'b1101);
    endtask

    task automatic t_reuse_collision();
        logic [3:0] r;
        attempt(CW, 32'hD000_0004, 32'hCAFE_0001, 1'b1, 1'b0, r);
        check("R8 new write captured and retried", r, 4'b1011);
        check("R8 new far request", {mst_req, mst_addr, mst_data}, {1'b1, 32'hD000_0004, 32'hCAFE_0001});
        attempt(CW, 32'hD000_0004, 32'hCAFE_0001, 1'b1, 1'b1, r);
        check("R11 attempt with abort retried", r, 4'b1011);
        check("R11 request dropped", mst_req, 1'b0);
    endtask

    task automatic t_complete_multi();
        logic [3:0] r;
        attempt(CW, 32'hD000_0004, 32'hCAFE_0001, 1'b1, 1'b0, r);
        check("R7 burst disconnect with data", r, 4'b1111);
        check("R7 entry released", mst_req, 1'b0);
    endtask

    task automatic t_stray_abort();
        logic [3:0] r;
        abort_pulse();
        check("R10 stray abort no request", mst_req, 1'b0);
        attempt(CW, 32'hE000_0008, 32'h0000_0077, 1'b0, 1'b0, r);
        check("R10 write after stray abort retried", r, 4'b1011);
        check("R10 captured", {mst_req, mst_addr}, {1'b1, 32'hE000_0008});
        abort_pulse();
        attempt(CW, 32'hE000_0008, 32'h0000_0077, 1'b0, 1'b0, r);
        check("R6 completion after fresh capture", r, 4'b1101);
    endtask

    initial begin
        rst = 1'b1; tgt_strobe = 1'b0; tgt_cmd = '0; tgt_addr = '0;
        tgt_wdata = '0; tgt_burst = 1'b0; mst_mabort = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_first();
        t_pending();
        t_mismatch();
        t_nonconfig();
        t_abort();
        t_done_mismatch();
        t_complete_single();
        t_reuse_collision();
        t_complete_multi();
        t_stray_abort();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog expired actual=hung expected=finished");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule